// File: doc/BRIEF.md
# Address Stability Handshake Monitor

This block is a synthesizable protocol checker for a single clock domain. It samples a bus address and a ready line on every rising clock edge. When the sampled address differs from the value taken on the previous edge, it opens a monitoring window. Inside that window the address has to keep its value on every edge, including the edge on which ready goes from 0 to 1. That rising edge of ready closes the window cleanly.

The monitor reports each outcome as a one-cycle pulse: a pass when a window closes cleanly, a stability error when the address moves inside a window, and a timeout when ready does not rise within a parameterised number of edges. Each pulse appears in the clock cycle that follows the deciding edge. Three saturating counters keep a running tally of the outcomes. The block is placed next to a bus responder and only observes it. It drives nothing back onto the bus.

Top module: `addr_hold_monitor`

## Requirements
- R1: While `rst_n` is low, all three pulse outputs and all three counters are 0, and any open window is discarded. A ready rise after reset is released therefore gives no pass for a window opened before the reset.
- R2: The first clock edge after reset is released only stores the address and ready values. It never opens a window, whatever the address was before.
- R3: When no window is open, an edge whose address differs from the previous edge's address opens a window and gives no pulse. Stability is checked from the following edge on.
- R4: If the address differs from its previous value on any edge inside an open window, `stab_err_o` is high for exactly the next cycle and the window is dropped. This includes the edge on which ready rises. A later ready rise then gives no pass.
- R5: Inside a window, an edge where `rdy_in` is 1, `rdy_in` was 0 on the previous edge, and the address is unchanged makes `pass_o` high for one cycle and closes the window. Ready held at 1 without a 0-to-1 step does not close the window.
- R6: If the window opened on edge t0 and no closing event occurs, `tmo_err_o` pulses after edge t0+TMO_LIMIT and the window closes. A ready rise on that same edge yields a pass instead.
- R7: A change of address on the first edge after a window has closed opens a new window immediately.
- R8: `pass_cnt_o`, `stab_cnt_o` and `tmo_cnt_o` each increase by one on the edge that raises their pulse. Each counter holds at all-ones once it reaches all-ones.
- R9: At most one of the three pulse outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | ADDR_W | Observed bus address |
| rdy_in | input | 1 | Observed responder ready |
| pass_o | output | 1 | Clean window close pulse |
| stab_err_o | output | 1 | Address moved inside window |
| tmo_err_o | output | 1 | Ready did not rise in time |
| pass_cnt_o | output | CNT_W | Saturating pass tally |
| stab_cnt_o | output | CNT_W | Saturating stability error tally |
| tmo_cnt_o | output | CNT_W | Saturating timeout tally |

## Verification
The bench builds the monitor with TMO_LIMIT set to 8 and CNT_W set to 3, which puts the timeout edge and the saturation point of the counters within a few dozen cycles. With these values, a window can be held open for the full eight edges both with and without a ready rise on the last one. Nine clean transactions in a row then drive the pass counter past its all-ones value of 7.

// File: rtl/amon_pkg.sv
package amon_pkg;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;

  // age value at which the window has seen LIMIT edges without closing
  function automatic int unsigned last_age(input int unsigned limit);
    return limit - 1;
  endfunction

  // width needed to count 0 .. limit-1, at least one bit
  function automatic int unsigned age_width(input int unsigned limit);
    return (limit > 2) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/amon_sampler.sv
module amon_sampler #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rdy_in,
  output logic              chg_o,
  output logic              rise_o
);

  logic [ADDR_W-1:0] addr_q;
  logic              rdy_q;
  logic              seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rdy_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      addr_q <= addr_in;
      rdy_q  <= rdy_in;
      seen_q <= 1'b1;
    end
  end

  // events are meaningful only once a previous sample exists
  assign chg_o  = seen_q && (addr_in != addr_q);
  assign rise_o = seen_q && rdy_in && !rdy_q;

endmodule

// File: rtl/amon_window.sv
module amon_window #(
  parameter int unsigned TMO_LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chg_i,
  input  logic rise_i,
  output logic win_o,
  output logic pass_ev_o,
  output logic stab_ev_o,
  output logic tmo_ev_o,
  output logic pass_q_o,
  output logic stab_q_o,
  output logic tmo_q_o
);
  import amon_pkg::*;

  localparam int unsigned AGE_W = age_width(TMO_LIMIT);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(last_age(TMO_LIMIT));

  win_state_e       state_q;
  logic [AGE_W-1:0] age_q;
  logic             in_win;
  logic             open_ev;

  assign in_win    = (state_q == WIN_OPEN);
  assign open_ev   = !in_win && chg_i;
  assign stab_ev_o = in_win && chg_i;
  assign pass_ev_o = in_win && !chg_i && rise_i;
  assign tmo_ev_o  = in_win && !chg_i && !rise_i && (age_q == AGE_LAST);
  assign win_o     = in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      age_q   <= '0;
    end else if (open_ev) begin
      state_q <= WIN_OPEN;
      age_q   <= '0;
    end else if (stab_ev_o || pass_ev_o || tmo_ev_o) begin
      state_q <= WIN_IDLE;
      age_q   <= '0;
    end else if (in_win) begin
      age_q   <= age_q + AGE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q_o <= 1'b0;
      stab_q_o <= 1'b0;
      tmo_q_o  <= 1'b0;
    end else begin
      pass_q_o <= pass_ev_o;
      stab_q_o <= stab_ev_o;
      tmo_q_o  <= tmo_ev_o;
    end
  end

endmodule

// File: rtl/amon_satctr.sv
module amon_satctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_o <= '0;
    else if (inc_i && cnt_o != TOP) cnt_o <= cnt_o + W'(1);
  end

endmodule

// File: rtl/addr_hold_monitor.sv
module addr_hold_monitor #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned TMO_LIMIT = 64,
  parameter int unsigned CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rdy_in,
  output logic              pass_o,
  output logic              stab_err_o,
  output logic              tmo_err_o,
  output logic [CNT_W-1:0]  pass_cnt_o,
  output logic [CNT_W-1:0]  stab_cnt_o,
  output logic [CNT_W-1:0]  tmo_cnt_o
);

  localparam int unsigned N_CNT = 3;

  logic             addr_chg;
  logic             rdy_rise;
  logic             win_open;
  logic             pass_ev, stab_ev, tmo_ev;
  logic [N_CNT-1:0] ev_vec;
  logic [CNT_W-1:0] cnt_arr [N_CNT];

  amon_sampler #(.ADDR_W(ADDR_W)) u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_in(addr_in),
    .rdy_in (rdy_in),
    .chg_o  (addr_chg),
    .rise_o (rdy_rise)
  );

  amon_window #(.TMO_LIMIT(TMO_LIMIT)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .chg_i    (addr_chg),
    .rise_i   (rdy_rise),
    .win_o    (win_open),
    .pass_ev_o(pass_ev),
    .stab_ev_o(stab_ev),
    .tmo_ev_o (tmo_ev),
    .pass_q_o (pass_o),
    .stab_q_o (stab_err_o),
    .tmo_q_o  (tmo_err_o)
  );

  assign ev_vec = {tmo_ev, stab_ev, pass_ev};

  for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
    amon_satctr #(.W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .inc_i(ev_vec[gi]),
      .cnt_o(cnt_arr[gi])
    );
  end

  assign pass_cnt_o = cnt_arr[0];
  assign stab_cnt_o = cnt_arr[1];
  assign tmo_cnt_o  = cnt_arr[2];

endmodule

// File: rtl/addr_hold_monitor_chk.sv
module addr_hold_monitor_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              rdy_in,
  input logic              win,
  input logic              pass_o,
  input logic              stab_err_o,
  input logic              tmo_err_o,
  input logic [CNT_W-1:0]  pass_cnt_o,
  input logic [CNT_W-1:0]  stab_cnt_o
);

  // R9
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass_o, stab_err_o, tmo_err_o}));

  // R5
  pass_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> ($past(rdy_in) && !$past(rdy_in, 2) && $past(addr_in) == $past(addr_in, 2)));

  // R4
  stab_moved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stab_err_o |-> ($past(addr_in) != $past(addr_in, 2)));

  // R4
  stab_drops_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stab_err_o |-> !win);

  // R6
  tmo_needs_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err_o |-> ($past(win) && !win));

  // R8
  pass_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> ((pass_cnt_o == $past(pass_cnt_o) + CNT_W'(1)) ||
                (pass_cnt_o == '1 && $past(pass_cnt_o) == '1)));

  // R8
  stab_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stab_err_o |-> $stable(stab_cnt_o));

endmodule

bind addr_hold_monitor addr_hold_monitor_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_in   (addr_in),
  .rdy_in    (rdy_in),
  .win       (win_open),
  .pass_o    (pass_o),
  .stab_err_o(stab_err_o),
  .tmo_err_o (tmo_err_o),
  .pass_cnt_o(pass_cnt_o),
  .stab_cnt_o(stab_cnt_o)
);

// File: tb/sim_addr_hold_monitor.sv
`timescale 1ns/1ps
module sim_addr_hold_monitor;
  localparam int unsigned AW    = 16;
  localparam int unsigned LIM   = 8;
  localparam int unsigned CW    = 3;
  localparam int          SATV  = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rdy = 1'b0;
  logic          pass_o, stab_err_o, tmo_err_o;
  logic [CW-1:0] pass_cnt_o, stab_cnt_o, tmo_cnt_o;

  int n_chk = 0;
  int n_bad = 0;
  int e_pass = 0, e_stab = 0, e_tmo = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  addr_hold_monitor #(.ADDR_W(AW), .TMO_LIMIT(LIM), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_in(addr), .rdy_in(rdy),
    .pass_o(pass_o), .stab_err_o(stab_err_o), .tmo_err_o(tmo_err_o),
    .pass_cnt_o(pass_cnt_o), .stab_cnt_o(stab_cnt_o), .tmo_cnt_o(tmo_cnt_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > SATV) ? SATV : v;
  endfunction

  // drive at a falling edge, return at the next falling edge
  task automatic cyc(input int a, input logic r);
    addr = AW'(a);
    rdy  = r;
    @(negedge clk);
  endtask

  // R9: exactly the expected pulse pattern, so never two at once
  task automatic pulses(input string tag, input int p, input int s, input int t);
    check({tag, " pass"}, int'(pass_o), p);
    check({tag, " stab"}, int'(stab_err_o), s);
    check({tag, " tmo"},  int'(tmo_err_o), t);
  endtask

  task automatic counts(input string tag);
    check({tag, " R8 pass_cnt"}, int'(pass_cnt_o), sat(e_pass));
    check({tag, " R8 stab_cnt"}, int'(stab_cnt_o), sat(e_stab));
    check({tag, " R8 tmo_cnt"},  int'(tmo_cnt_o),  sat(e_tmo));
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    pulses("R1 in reset", 0, 0, 0);
    counts("R1 in reset");
    rst_n = 1'b1;
  endtask

  task automatic t_first_edge();
    cyc(5, 0);  pulses("R2 first edge", 0, 0, 0);
    cyc(5, 0);  pulses("R2 hold", 0, 0, 0);
    cyc(5, 1);  pulses("R2 no window on rise", 0, 0, 0);
    cyc(5, 0);
  endtask

  task automatic t_clean();
    cyc(6, 0);  pulses("R3 open", 0, 0, 0);
    cyc(6, 0);  cyc(6, 0);
    pulses("R3 stable", 0, 0, 0);
    cyc(6, 1);  e_pass++;
    pulses("R5 clean close", 1, 0, 0);
    counts("R8 after pass");
    cyc(6, 0);  pulses("R5 pulse one cycle", 0, 0, 0);
  endtask

  task automatic t_violate();
    cyc(7, 0);  cyc(7, 0);
    cyc(8, 0);  e_stab++;
    pulses("R4 moved", 0, 1, 0);
    counts("R8 after stab");
    cyc(8, 0);  pulses("R4 pulse one cycle", 0, 0, 0);
    cyc(8, 0);
    cyc(8, 1);  pulses("R4 abandoned, no pass", 0, 0, 0);
    cyc(8, 0);
  endtask

  task automatic t_level();
    cyc(8, 1);
    cyc(9, 1);  pulses("R5 open while ready high", 0, 0, 0);
    cyc(9, 1);  cyc(9, 1);
    pulses("R5 level does not close", 0, 0, 0);
    cyc(9, 0);  pulses("R5 ready low", 0, 0, 0);
    cyc(9, 1);  e_pass++;
    pulses("R5 close on rise", 1, 0, 0);
    cyc(9, 0);
  endtask

  task automatic t_rise_move();
    cyc(10, 0); cyc(10, 0);
    cyc(11, 1); e_stab++;
    pulses("R4 move on rise edge", 0, 1, 0);
    cyc(11, 0); counts("R8 after rise move");
  endtask

  task automatic t_timeout();
    cyc(12, 0);
    for (int i = 0; i < int'(LIM) - 1; i++) cyc(12, 0);
    pulses("R6 before limit", 0, 0, 0);
    cyc(12, 0); e_tmo++;
    pulses("R6 timeout", 0, 0, 1);
    counts("R6 count");
    cyc(12, 0); pulses("R6 window closed", 0, 0, 0);
    cyc(13, 0);
    for (int i = 0; i < int'(LIM) - 1; i++) cyc(13, 0);
    cyc(13, 1); e_pass++;
    pulses("R6 rise on limit edge", 1, 0, 0);
    cyc(13, 0);
  endtask

  task automatic t_back2back();
    cyc(14, 0);
    cyc(14, 1); e_pass++;
    pulses("R7 first close", 1, 0, 0);
    cyc(15, 0); pulses("R7 reopen", 0, 0, 0);
    cyc(15, 0);
    cyc(15, 1); e_pass++;
    pulses("R7 second close", 1, 0, 0);
    counts("R7 counts");
    cyc(15, 0);
  endtask

  task automatic t_reset_discard();
    cyc(16, 0);
    rst_n = 1'b0;
    e_pass = 0; e_stab = 0; e_tmo = 0;
    cyc(16, 0); cyc(17, 0);
    pulses("R1 reset mid window", 0, 0, 0);
    counts("R1 counters cleared");
    rst_n = 1'b1;
    cyc(18, 0); pulses("R2 first edge after reset", 0, 0, 0);
    cyc(18, 0);
    cyc(18, 1); pulses("R1 window discarded", 0, 0, 0);
    cyc(18, 0);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 9; k++) begin
      cyc(20 + k, 0);
      cyc(20 + k, 0);
      cyc(20 + k, 1); e_pass++;
      pulses("R8 sat loop", 1, 0, 0);
      cyc(20 + k, 0);
    end
    counts("R8 saturated");
  endtask

  initial begin
    t_reset_state();
    t_first_edge();
    t_clean();
    t_violate();
    t_level();
    t_rise_move();
    t_timeout();
    t_back2back();
    t_reset_discard();
    t_saturate();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule